// File: doc/BRIEF.md
# Windowed Latch-Off Protection Logic

This block makes the digital decisions behind a protection pin that must stay inside a voltage window for a switching power controller to keep running. Two comparator outputs arrive from the analog side. One reports that the pin has risen above the upper (overvoltage) threshold. The other reports that it has dropped below the lower (overtemperature) threshold. Each comparator is brought into the clock domain by a two-flop synchronizer. Each is then filtered by its own blanking counter, so that only an excursion lasting at least the configured number of clock cycles is acted upon.

The two thresholds arm at different points of start-up. Neither is honoured before the supply reaches its turn-on level. The upper one is honoured from that moment, and the driver does not begin switching while it is active. The lower one is honoured only after soft-start has finished. A qualified excursion sets a sticky latch-off flag that holds the driver off. Only a brown-out indication or a supply-reset indication clears it. During soft-start the block also requests double the normal pin bias current, so that the pin capacitor charges faster.

Top module: `latchoff_top`

## Requirements
- R1: While reset is applied and on the first cycle after it, `latchedOff`, `drvEnable` and `doubleBias` are all 0.
- R2: When `supplyReady` is 1, an upper-threshold excursion sampled at 1 on HIGH_BLANK consecutive rising edges sets `latchedOff` within HIGH_BLANK+2 cycles. One sampled on HIGH_BLANK-1 or fewer edges leaves it at 0.
- R3: Once soft-start has finished, a lower-threshold excursion sampled at 1 on LOW_BLANK consecutive rising edges sets `latchedOff`. One sampled on LOW_BLANK-1 or fewer edges leaves it at 0.
- R4: While `supplyReady` is 0, neither comparator input can set `latchedOff`, whatever its duration.
- R5: After `supplyReady` rises and before `softStartDone` has been seen at 1, the lower-threshold input cannot set `latchedOff`, while the upper-threshold input still can.
- R6: If the upper comparator is already active when `supplyReady` rises, `drvEnable` stays 0 from then on. If the excursion ends before qualifying, the driver starts within four cycles after it ends.
- R7: `doubleBias` is 1 exactly when `supplyReady` is 1, `softStartActive` is 1 and soft-start has not yet been seen done since `supplyReady` rose.
- R8: Once set, `latchedOff` stays 1 until `brownOut` or `supplyReset` is sampled at 1. On the edge after that it is 0. A clear request wins over a simultaneous trip.
- R9: `drvEnable` is a register. It is 1 only in the cycle after one in which `supplyReady` was 1 and `thermalStop` was 0, and never while `latchedOff` is 1.
- R10: A blanking counter restarts whenever its synchronized input drops. Two sub-threshold pulses separated by a gap do not add up to a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmpHigh | input | 1 | Asynchronous comparator: pin above upper threshold |
| cmpLow | input | 1 | Asynchronous comparator: pin below lower threshold |
| supplyReady | input | 1 | Supply has reached its turn-on level |
| softStartActive | input | 1 | Soft-start ramp in progress |
| softStartDone | input | 1 | Soft-start ramp has completed |
| brownOut | input | 1 | Brown-out detected; clears the latch |
| supplyReset | input | 1 | Supply fell to the reset level; clears the latch |
| thermalStop | input | 1 | Die over-temperature shutdown active |
| drvEnable | output | 1 | Registered permission for the driver to switch |
| latchedOff | output | 1 | Sticky latch-off flag |
| doubleBias | output | 1 | Request for doubled pin bias current |

## Verification
The assertions assume that `supplyReady`, `softStartActive`, `softStartDone`, `brownOut`, `supplyReset` and `thermalStop` are already synchronous to `clk`. They also assume that `supplyReady` is held at 0 while reset is applied. Only the two comparator lines may change asynchronously. The stimulus changes every input on the falling edge and holds the status lines at 0 throughout reset, so the rising-edge sampling never sees a change in progress. The bench uses small blanking values, which lets it sweep every pulse width from one cycle up to past the limit for both thresholds in every start-up phase.

// File: rtl/latchoff_pkg.sv
package latchoff_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_SOFT = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic armHigh;
    logic armLow;
    logic clrCnt;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic highLevel;
    logic tripHigh;
    logic tripLow;
  } dpStatus_t;

endpackage

// File: rtl/latchoff_blank.sv
module latchoff_blank #(
  parameter int BLANK       = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmpIn,
  input  logic arm,
  input  logic clr,
  output logic level,
  output logic trip
);
  localparam int CNT_W = $clog2(BLANK + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLANK - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], cmpIn};
  end

  assign level = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (clr || !arm || !level) cnt <= '0;
    else if (cnt != CNT_LAST)       cnt <= cnt + 1'b1;
  end

  assign trip = arm && level && !clr && (cnt == CNT_LAST);
endmodule

// File: rtl/latchoff_datapath.sv
module latchoff_datapath
  import latchoff_pkg::*;
#(
  parameter int HIGH_BLANK  = 50,
  parameter int LOW_BLANK   = 350,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmpHigh,
  input  logic        cmpLow,
  input  ctlStrobes_t strobes,
  output dpStatus_t   status
);
  localparam int NCH = 2;

  logic [NCH-1:0] chIn, chArm, chLevel, chTrip;

  assign chIn  = {cmpLow, cmpHigh};
  assign chArm = {strobes.armLow, strobes.armHigh};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int B = (i == 0) ? HIGH_BLANK : LOW_BLANK;
    latchoff_blank #(.BLANK(B), .SYNC_STAGES(SYNC_STAGES)) blank_i (
      .clk  (clk),
      .rstN (rstN),
      .cmpIn(chIn[i]),
      .arm  (chArm[i]),
      .clr  (strobes.clrCnt),
      .level(chLevel[i]),
      .trip (chTrip[i])
    );
  end

  assign status.highLevel = chLevel[0];
  assign status.tripHigh  = chTrip[0];
  assign status.tripLow   = chTrip[1];
endmodule

// File: rtl/latchoff_control.sv
module latchoff_control
  import latchoff_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyReady,
  input  logic        softStartActive,
  input  logic        softStartDone,
  input  logic        brownOut,
  input  logic        supplyReset,
  input  logic        thermalStop,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        drvEnable,
  output logic        latchedOff,
  output logic        doubleBias
);
  phase_t phase, phaseNext;
  logic   latchNext, clearReq, started, drvNext;

  always_comb begin
    phaseNext = phase;
    if (!supplyReady) phaseNext = PH_WAIT;
    else begin
      case (phase)
        PH_WAIT: phaseNext = PH_SOFT;
        PH_SOFT: if (softStartDone) phaseNext = PH_RUN;
        default: phaseNext = phase;
      endcase
    end
  end

  assign clearReq        = brownOut || supplyReset;
  assign strobes.armHigh = supplyReady && (phase != PH_WAIT);
  assign strobes.armLow  = supplyReady && (phase == PH_RUN);
  assign strobes.clrCnt  = clearReq;

  assign latchNext = clearReq ? 1'b0
                   : (latchedOff || status.tripHigh || status.tripLow);

  // driver may not begin while an upper excursion is pending at start
  assign drvNext = supplyReady && !latchNext && !thermalStop
                   && (started || !status.highLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_WAIT;
      latchedOff <= 1'b0;
      drvEnable  <= 1'b0;
      started    <= 1'b0;
    end else begin
      phase      <= phaseNext;
      latchedOff <= latchNext;
      drvEnable  <= drvNext;
      if (!supplyReady) started <= 1'b0;
      else if (drvNext) started <= 1'b1;
    end
  end

  assign doubleBias = supplyReady && softStartActive && (phase != PH_RUN);
endmodule

// File: rtl/latchoff_top.sv
module latchoff_top
  import latchoff_pkg::*;
#(
  parameter int HIGH_BLANK  = 50,
  parameter int LOW_BLANK   = 350,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmpHigh,
  input  logic cmpLow,
  input  logic supplyReady,
  input  logic softStartActive,
  input  logic softStartDone,
  input  logic brownOut,
  input  logic supplyReset,
  input  logic thermalStop,
  output logic drvEnable,
  output logic latchedOff,
  output logic doubleBias
);
  ctlStrobes_t strobes;
  dpStatus_t   status;

  latchoff_datapath #(
    .HIGH_BLANK (HIGH_BLANK),
    .LOW_BLANK  (LOW_BLANK),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .cmpHigh(cmpHigh),
    .cmpLow (cmpLow),
    .strobes(strobes),
    .status (status)
  );

  latchoff_control ctl_i (
    .clk            (clk),
    .rstN           (rstN),
    .supplyReady    (supplyReady),
    .softStartActive(softStartActive),
    .softStartDone  (softStartDone),
    .brownOut       (brownOut),
    .supplyReset    (supplyReset),
    .thermalStop    (thermalStop),
    .status         (status),
    .strobes        (strobes),
    .drvEnable      (drvEnable),
    .latchedOff     (latchedOff),
    .doubleBias     (doubleBias)
  );
endmodule

// File: rtl/latchoff_checker.sv
module latchoff_checker (
  input logic clk,
  input logic rstN,
  input logic supplyReady,
  input logic softStartActive,
  input logic brownOut,
  input logic supplyReset,
  input logic thermalStop,
  input logic drvEnable,
  input logic latchedOff,
  input logic doubleBias
);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (latchedOff && !brownOut && !supplyReset) |=> latchedOff);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brownOut || supplyReset) |=> !latchedOff);

  p_no_early_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyReady && !latchedOff) |=> !latchedOff);

  p_drv_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    drvEnable |-> (!latchedOff && $past(supplyReady) && !$past(thermalStop)));

  p_bias_r7: assert property (@(posedge clk) disable iff (!rstN)
    doubleBias |-> (supplyReady && softStartActive));
endmodule

bind latchoff_top latchoff_checker chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .supplyReady    (supplyReady),
  .softStartActive(softStartActive),
  .brownOut       (brownOut),
  .supplyReset    (supplyReset),
  .thermalStop    (thermalStop),
  .drvEnable      (drvEnable),
  .latchedOff     (latchedOff),
  .doubleBias     (doubleBias)
);

// File: tb/latchoff_top_tb.sv
`timescale 1ns/1ps
module latchoff_top_tb_top;
  localparam int HB = 5;
  localparam int LB = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpHigh = 0, cmpLow = 0, supplyReady = 0, softStartActive = 0;
  logic softStartDone = 0, brownOut = 0, supplyReset = 0, thermalStop = 0;
  logic drvEnable, latchedOff, doubleBias;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  latchoff_top #(.HIGH_BLANK(HB), .LOW_BLANK(LB)) dut_i (
    .clk(clk), .rstN(rstN), .cmpHigh(cmpHigh), .cmpLow(cmpLow),
    .supplyReady(supplyReady), .softStartActive(softStartActive),
    .softStartDone(softStartDone), .brownOut(brownOut),
    .supplyReset(supplyReset), .thermalStop(thermalStop),
    .drvEnable(drvEnable), .latchedOff(latchedOff), .doubleBias(doubleBias)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearLatch();
    brownOut = 1; cyc(1); brownOut = 0; cyc(2);
  endtask

  task automatic goSoft();
    supplyReady = 1; softStartActive = 1; softStartDone = 0; cyc(HB + 4);
  endtask

  task automatic goRun();
    softStartActive = 0; softStartDone = 1; cyc(3);
  endtask

  task automatic powerDown();
    supplyReady = 0; softStartActive = 0; softStartDone = 0; cyc(3);
  endtask

  // pulse on one comparator for w sampled edges, then wait to settle
  task automatic pulse(input bit high, input int w);
    if (high) cmpHigh = 1; else cmpLow = 1;
    cyc(w);
    cmpHigh = 0; cmpLow = 0;
    cyc(4);
  endtask

  initial begin
    cyc(3);
    check("R1 latch in reset", latchedOff, 0);
    check("R1 drv in reset", drvEnable, 0);
    rstN = 1;
    cyc(1);
    check("R1 latch after reset", latchedOff, 0);
    check("R1 drv after reset", drvEnable, 0);
    check("R1 bias after reset", doubleBias, 0);

    // R4: supply not ready, long excursions ignored
    pulse(1, HB + 4);
    check("R4 high ignored before supply", latchedOff, 0);
    pulse(0, LB + 4);
    check("R4 low ignored before supply", latchedOff, 0);
    check("R4 drv off before supply", drvEnable, 0);

    // R7 / R5: soft-start phase
    goSoft();
    check("R7 bias during soft-start", doubleBias, 1);
    check("R9 drv on when ready", drvEnable, 1);
    softStartActive = 0; cyc(1);
    check("R7 bias needs soft-start active", doubleBias, 0);
    softStartActive = 1; cyc(1);
    for (int w = 1; w <= LB + 3; w++) begin
      pulse(0, w);
      check($sformatf("R5 low ignored in soft-start w=%0d", w), latchedOff, 0);
    end
    pulse(1, HB + 1);
    check("R5 high honoured in soft-start", latchedOff, 1);
    clearLatch();

    // R2 sweep, soft-start phase and run phase
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) begin
        goRun();
        check("R7 bias off after soft-start done", doubleBias, 0);
        softStartActive = 1; cyc(1);
        check("R7 bias stays off in run", doubleBias, 0);
        softStartActive = 0;
      end
      for (int w = 1; w <= HB + 2; w++) begin
        pulse(1, w);
        check($sformatf("R2 high w=%0d ph=%0d", w, ph), latchedOff, (w >= HB) ? 1 : 0);
        check($sformatf("R9 drv vs latch w=%0d", w), drvEnable, (w >= HB) ? 0 : 1);
        if (latchedOff) clearLatch();
      end
    end

    // R3 sweep in run phase
    for (int w = 1; w <= LB + 2; w++) begin
      pulse(0, w);
      check($sformatf("R3 low w=%0d", w), latchedOff, (w >= LB) ? 1 : 0);
      if (latchedOff) clearLatch();
    end

    // R10: split pulses do not accumulate
    cmpHigh = 1; cyc(HB - 1); cmpHigh = 0; cyc(1);
    cmpHigh = 1; cyc(HB - 1); cmpHigh = 0; cyc(4);
    check("R10 high restart", latchedOff, 0);
    cmpLow = 1; cyc(LB - 1); cmpLow = 0; cyc(1);
    cmpLow = 1; cyc(LB - 1); cmpLow = 0; cyc(4);
    check("R10 low restart", latchedOff, 0);

    // R8: sticky, cleared by either source
    pulse(1, HB);
    cyc(20);
    check("R8 latch sticky", latchedOff, 1);
    supplyReset = 1; cyc(1); supplyReset = 0;
    check("R8 supply reset clears", latchedOff, 0);
    pulse(0, LB);
    check("R8 latch set again", latchedOff, 1);
    brownOut = 1; cyc(1); brownOut = 0;
    check("R8 brown-out clears", latchedOff, 0);
    cmpHigh = 1; brownOut = 1; cyc(HB + 4);
    check("R8 clear wins over trip", latchedOff, 0);
    cmpHigh = 0; brownOut = 0; cyc(4);
    check("R8 no trip after clear", latchedOff, 0);

    // R9: thermal stop
    cyc(2);
    check("R9 drv running", drvEnable, 1);
    thermalStop = 1; cyc(1);
    check("R9 thermal stop", drvEnable, 0);
    check("R9 thermal no latch", latchedOff, 0);
    thermalStop = 0; cyc(1);
    check("R9 thermal release", drvEnable, 1);

    // R6: upper excursion present at supply-on
    powerDown();
    cmpHigh = 1; cyc(4);
    supplyReady = 1; softStartActive = 1;
    for (int i = 0; i < HB + 6; i++) begin
      cyc(1);
      check($sformatf("R6 no start i=%0d", i), drvEnable, 0);
    end
    check("R6 latched after start", latchedOff, 1);
    cmpHigh = 0;
    powerDown();
    clearLatch();
    cmpHigh = 1; cyc(4);
    supplyReady = 1; cyc(2);
    check("R6 held while pending", drvEnable, 0);
    cmpHigh = 0; cyc(4);
    check("R6 starts after excursion ends", drvEnable, 1);
    check("R6 no latch from short", latchedOff, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule